// File: doc/BRIEF.md
# Four-Lane 7:1 Serial-to-Parallel Receiver

This block rebuilds a 28-bit parallel word from four serial data lanes and a forwarded frame clock. A bit clock at seven times the frame rate is supplied from outside. Every bit-clock cycle the block samples each lane and the frame clock once. The frame clock, seen as a serial stream, repeats four high samples followed by three low ones, and its rising transition marks bit 0 of every frame.

Seven bits per lane are gathered in per-lane shift registers. At the end of each frame the assembled word moves to an output register. A regenerated frame-rate clock goes out with the word: the word changes at that clock's rising edge and holds steady through its falling edge. A lock qualifier keeps the output at zero until the frame clock has shown the expected pattern for several frames in a row.

An active-low shutdown input clears all state at once and holds the output clock low for as long as it is asserted.

Top module: `quad_lane_deser`

## Requirements
- R1: Lane n fills output bits [7n+6:7n], and the first bit received in a frame lands in the lowest of those seven bits, giving 4 x 7 = 28 output bits.
- R2: Lanes and frame clock are each sampled once per bit clock. A sample in which the frame clock is high and was low one sample earlier is bit 0 of a frame. The expected frame-clock pattern by bit index 0..6 is high, high, high, high, low, low, low.
- R3: The output word changes at most once per frame. The change happens on the bit-clock edge that follows the edge at which the input register captured bit 6, which is the same edge that captures the next frame's bit 0.
- R4: The output clock is high for four bit periods and low for three. It rises on the same edge that updates the word, so the word is stable at its falling edge.
- R5: The lock flag rises after three consecutive frames whose frame-clock samples all match the pattern. The third such frame's word is the first one presented. While the lock flag is low, the output word is zero.
- R6: A frame-clock sample that departs from the expected pattern clears the lock flag and the output word on the next edge. The next rising transition of the frame clock restarts alignment.
- R7: A low level on the shutdown input clears the output word, the lock flag and the output clock at once, without waiting for a clock edge, and holds the output clock low for as long as the input stays low.
- R8: After shutdown is released, the words of the first two received frames come out as zero.
- R9: For arbitrary data, the output word equals the word that was serialized onto the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock, seven times the frame rate |
| shutdownN | input | 1 | Active-low shutdown and asynchronous clear |
| frameClkIn | input | 1 | Forwarded frame clock, sampled as data |
| laneIn | input | 4 | Serial data lanes, one bit per lane per bit clock |
| wordOut | output | 28 | Recovered parallel word |
| clkOut | output | 1 | Regenerated frame-rate output clock |
| locked | output | 1 | Frame alignment lock flag |

## Verification
Inputs are driven on the falling bit-clock edge. The word and lock flag for a frame are therefore due two rising edges after that frame's bit 6 is driven: one edge for the input register and one for the output register. The bench compares them at the falling edge just before it drives bit 1 of the following frame. When an idle gap follows, the comparison moves to the second gap sample, which is before the gap's pattern fault clears the word. The output clock lags the frame clock by one sample and is checked at every falling edge of frames that follow an aligned frame. Shutdown acts asynchronously, so its effect is checked 1 ns after the input falls, and then at each falling edge while it stays low.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Strobes from the framing control to the datapath, valid for one bit period.
  typedef struct packed {
    logic captureWord;  // last bit of a good frame while lock is reached or held
    logic clearWord;    // frame-clock pattern fault seen this cycle
  } deser_strobes_t;

endpackage

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int BITS        = 7,
  parameter int HIGH_BITS   = 4,
  parameter int LOCK_FRAMES = 3
) (
  input  logic           bitClk,
  input  logic           shutdownN,
  input  logic           frameClkIn,
  output deser_strobes_t strobes,
  output logic           clkOut,
  output logic           locked
);

  localparam int PW = $clog2(BITS);
  localparam int CW = $clog2(LOCK_FRAMES) + 1;
  localparam logic [PW-1:0] LAST_IDX  = PW'(BITS - 1);
  localparam logic [PW-1:0] HIGH_LIM  = PW'(HIGH_BITS);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_FRAMES - 1);

  logic          frameQ;
  logic          framePrev;
  logic [PW-1:0] phase;
  logic [PW-1:0] bitIdx;
  logic [PW-1:0] nextIdx;
  logic          frameBad;
  logic          frameBadNow;
  logic          riseSeen;
  logic          expectHigh;
  logic          mismatch;
  logic          frameEnd;
  logic [CW-1:0] goodCnt;

  // Bit index of the sample currently held in the input registers.
  always_comb begin
    riseSeen    = frameQ & ~framePrev;
    bitIdx      = riseSeen ? '0 : phase;
    expectHigh  = (bitIdx < HIGH_LIM);
    mismatch    = (frameQ != expectHigh);
    frameEnd    = (bitIdx == LAST_IDX);
    nextIdx     = frameEnd ? '0 : bitIdx + 1'b1;
    frameBadNow = mismatch | ((bitIdx != '0) & frameBad);
    strobes.captureWord = frameEnd & ~frameBadNow & (locked | (goodCnt == LOCK_LAST));
    strobes.clearWord   = mismatch;
  end

  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      frameQ    <= 1'b0;
      framePrev <= 1'b0;
      phase     <= '0;
      frameBad  <= 1'b0;
      goodCnt   <= '0;
      locked    <= 1'b0;
      clkOut    <= 1'b0;
    end else begin
      frameQ    <= frameClkIn;
      framePrev <= frameQ;
      phase     <= nextIdx;
      frameBad  <= frameBadNow;
      clkOut    <= (nextIdx < HIGH_LIM);
      if (mismatch) begin
        locked  <= 1'b0;
        goodCnt <= '0;
      end else if (frameEnd && !frameBadNow && !locked) begin
        if (goodCnt == LOCK_LAST) locked <= 1'b1;
        else                      goodCnt <= goodCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BITS  = 7
) (
  input  logic                   bitClk,
  input  logic                   shutdownN,
  input  logic [LANES-1:0]       laneIn,
  input  deser_strobes_t         strobes,
  output logic [LANES*BITS-1:0]  wordOut
);

  localparam int WORD_W = LANES * BITS;

  logic [LANES-1:0]  laneQ;
  logic [WORD_W-1:0] assembled;

  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) laneQ <= '0;
    else            laneQ <= laneIn;
  end

  // Per lane: six earlier bits shift toward the LSB; the current sample completes the group.
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [BITS-2:0] shiftQ;
    always_ff @(posedge bitClk or negedge shutdownN) begin
      if (!shutdownN) shiftQ <= '0;
      else            shiftQ <= {laneQ[n], shiftQ[BITS-2:1]};
    end
    assign assembled[n*BITS +: BITS] = {laneQ[n], shiftQ};
  end

  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN)               wordOut <= '0;
    else if (strobes.clearWord)   wordOut <= '0;
    else if (strobes.captureWord) wordOut <= assembled;
  end

endmodule

// File: rtl/quad_lane_deser.sv
module quad_lane_deser
  import deser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int BITS        = 7,
  parameter int HIGH_BITS   = 4,
  parameter int LOCK_FRAMES = 3
) (
  input  logic                  bitClk,
  input  logic                  shutdownN,
  input  logic                  frameClkIn,
  input  logic [LANES-1:0]      laneIn,
  output logic [LANES*BITS-1:0] wordOut,
  output logic                  clkOut,
  output logic                  locked
);

  localparam int WORD_W = LANES * BITS;

  deser_strobes_t strobes;

  deser_ctrl #(
    .BITS       (BITS),
    .HIGH_BITS  (HIGH_BITS),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) ctrl_i (
    .bitClk    (bitClk),
    .shutdownN (shutdownN),
    .frameClkIn(frameClkIn),
    .strobes   (strobes),
    .clkOut    (clkOut),
    .locked    (locked)
  );

  deser_datapath #(
    .LANES(LANES),
    .BITS (BITS)
  ) dp_i (
    .bitClk   (bitClk),
    .shutdownN(shutdownN),
    .laneIn   (laneIn),
    .strobes  (strobes),
    .wordOut  (wordOut)
  );

endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int WORD_W = 28
) (
  input logic              bitClk,
  input logic              shutdownN,
  input logic [WORD_W-1:0] wordOut,
  input logic              clkOut,
  input logic              locked
);

  p_zero_unlocked_r5: assert property (@(posedge bitClk) disable iff (!shutdownN)
    !locked |-> (wordOut == '0));

  p_lock_on_clk_rise_r5: assert property (@(posedge bitClk) disable iff (!shutdownN)
    $rose(locked) |-> $rose(clkOut));

  p_update_on_clk_rise_r3: assert property (@(posedge bitClk) disable iff (!shutdownN)
    (locked && $past(locked) && (wordOut != $past(wordOut))) |-> $rose(clkOut));

  p_clk_high_width_r4: assert property (@(posedge bitClk) disable iff (!shutdownN)
    $rose(clkOut) |=> clkOut);

  p_shutdown_clear_r7: assert property (@(posedge bitClk)
    !shutdownN |-> ((wordOut == '0) && !clkOut && !locked));

endmodule

bind quad_lane_deser deser_checker #(.WORD_W(WORD_W)) chk_i (
  .bitClk   (bitClk),
  .shutdownN(shutdownN),
  .wordOut  (wordOut),
  .clkOut   (clkOut),
  .locked   (locked)
);

// File: tb/quad_lane_deser_tb_top.sv
module quad_lane_deser_tb_top;

  localparam int LANES  = 4;
  localparam int BITS   = 7;
  localparam int WORD_W = LANES * BITS;
  localparam logic [BITS-1:0] NORMAL_PAT = 7'b0001111;  // bit j = frame clock at index j

  logic              bitClk     = 1'b0;
  logic              shutdownN  = 1'b1;
  logic              frameClkIn = 1'b0;
  logic [LANES-1:0]  laneIn     = '0;
  logic [WORD_W-1:0] wordOut;
  logic              clkOut;
  logic              locked;

  int vectors = 0;
  int misses  = 0;
  int goodRun = 0;
  bit pendingValid  = 1'b0;
  bit pendingLocked = 1'b0;
  bit prevNormal    = 1'b0;
  logic [WORD_W-1:0] pendingWord = '0;
  string pendingTag = "";

  always #10 bitClk = ~bitClk;

  quad_lane_deser #(
    .LANES(LANES), .BITS(BITS), .HIGH_BITS(4), .LOCK_FRAMES(3)
  ) dut_i (
    .bitClk(bitClk), .shutdownN(shutdownN), .frameClkIn(frameClkIn),
    .laneIn(laneIn), .wordOut(wordOut), .clkOut(clkOut), .locked(locked)
  );

  task automatic checkVal(input string req, input logic [31:0] actual, input logic [31:0] expected);
    vectors++;
    if (actual !== expected) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic checkPending();
    if (pendingValid) begin
      checkVal(pendingTag, 32'(wordOut), 32'(pendingWord));
      checkVal("R5 lock flag", 32'(locked), 32'(pendingLocked));
    end
    pendingValid = 1'b0;
  endtask

  function automatic logic [BITS-1:0] corruptPat(input int pos);
    logic [BITS-1:0] p = NORMAL_PAT;
    p[pos] = ~p[pos];
    return p;
  endfunction

  // Serializer model: lane n, bit j carries data[n*BITS + j].
  task automatic sendFrame(input logic [WORD_W-1:0] data, input logic [BITS-1:0] pat, input string tag);
    bit normal = (pat == NORMAL_PAT);
    for (int j = 0; j < BITS; j++) begin
      @(negedge bitClk);
      if (j == 1) checkPending();
      if (normal && prevNormal) checkVal("R4 output clock", 32'(clkOut), 32'((j >= 1) && (j <= 4)));
      frameClkIn = pat[j];
      for (int n = 0; n < LANES; n++) laneIn[n] = data[n*BITS + j];
    end
    if (normal) goodRun++;
    else        goodRun = 0;
    pendingValid  = 1'b1;
    pendingLocked = (goodRun >= 3);
    pendingWord   = (goodRun >= 3) ? data : '0;
    pendingTag    = normal ? tag : "R6 word after pattern fault";
    prevNormal    = normal;
  endtask

  task automatic sendGap(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge bitClk);
      if (k == 1) checkPending();
      frameClkIn = 1'b0;
      laneIn     = LANES'($urandom);
    end
    goodRun       = 0;
    pendingValid  = 1'b1;
    pendingLocked = 1'b0;
    pendingWord   = '0;
    pendingTag    = "R6 word after slip";
    prevNormal    = 1'b0;
  endtask

  task automatic holdShutdown(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge bitClk);
      checkVal("R7 clock held low", 32'(clkOut), 32'd0);
      checkVal("R7 word cleared", 32'(wordOut), 32'd0);
      frameClkIn = 1'($urandom);
      laneIn     = LANES'($urandom);
    end
    @(negedge bitClk);
    frameClkIn   = 1'b0;
    shutdownN    = 1'b1;
    goodRun      = 0;
    pendingValid = 1'b0;
    prevNormal   = 1'b0;
  endtask

  task automatic doShutdown(input int cycles);
    @(negedge bitClk);
    shutdownN = 1'b0;
    #1;
    checkVal("R7 async word clear", 32'(wordOut), 32'd0);
    checkVal("R7 async clock clear", 32'(clkOut), 32'd0);
    checkVal("R7 async lock clear", 32'(locked), 32'd0);
    holdShutdown(cycles);
  endtask

  function automatic logic [WORD_W-1:0] randWord();
    return WORD_W'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd5150));
    #2 shutdownN = 1'b0;
    #1;
    checkVal("R7 reset word", 32'(wordOut), 32'd0);
    checkVal("R7 reset clock", 32'(clkOut), 32'd0);
    checkVal("R7 reset lock", 32'(locked), 32'd0);
    holdShutdown(8);

    // Bring-up: two zero words, then the third frame appears (R8, R5).
    sendFrame(randWord(), NORMAL_PAT, "R8 first frame after release");
    sendFrame(randWord(), NORMAL_PAT, "R8 second frame after release");
    sendFrame(randWord(), NORMAL_PAT, "R5 first locked word");

    // Directed data patterns (R9) and lane/bit placement (R1, R2).
    sendFrame({WORD_W{1'b1}}, NORMAL_PAT, "R9 all ones");
    sendFrame('0, NORMAL_PAT, "R9 all zeros");
    sendFrame(28'h5555555, NORMAL_PAT, "R9 alternating");
    for (int n = 0; n < LANES; n++) begin
      for (int j = 0; j < BITS; j++) begin
        sendFrame(WORD_W'(1) << (n*BITS + j), NORMAL_PAT, "R1 R2 walking one");
      end
    end

    // Pattern fault inside a frame: lock drops, three good frames relock (R6, R5).
    sendFrame(randWord(), corruptPat(4), "R6");
    @(negedge bitClk);
    checkVal("R6 lock dropped", 32'(locked), 32'd0);
    checkVal("R6 word cleared", 32'(wordOut), 32'd0);
    prevNormal = 1'b0;
    sendFrame(randWord(), NORMAL_PAT, "R6 realign frame 1");
    sendFrame(randWord(), NORMAL_PAT, "R6 realign frame 2");
    sendFrame(randWord(), NORMAL_PAT, "R5 relocked word");
    sendFrame(randWord(), NORMAL_PAT, "R9 word");

    // Frame slip by an idle gap (R6, R2).
    sendGap(3);
    sendFrame(randWord(), NORMAL_PAT, "R2 after slip 1");
    sendFrame(randWord(), NORMAL_PAT, "R2 after slip 2");
    sendFrame(randWord(), NORMAL_PAT, "R2 after slip relocked");
    sendFrame(randWord(), NORMAL_PAT, "R9 word");

    // Shutdown while locked (R7, R8).
    doShutdown(10);
    sendFrame(randWord(), NORMAL_PAT, "R8 first frame after release");
    sendFrame(randWord(), NORMAL_PAT, "R8 second frame after release");
    sendFrame(randWord(), NORMAL_PAT, "R5 first locked word");

    // Random traffic with occasional faults.
    for (int i = 0; i < 320; i++) begin
      int sel = int'($urandom % 32);
      if (sel == 0)      sendFrame(randWord(), corruptPat(1 + int'($urandom % 5)), "R6");
      else if (sel == 1) sendGap(2 + int'($urandom % 4));
      else if (sel == 2) doShutdown(2 + int'($urandom % 6));
      else               sendFrame(randWord(), NORMAL_PAT, (goodRun >= 2) ? "R9 random word" : "R5 R8 word before lock");
    end
    sendGap(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bitClk);
    misses++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule